// File: doc/BRIEF.md
# LCD Backplane Source Selector

This block decides where an LCD backplane waveform comes from and drives it. After reset is released it watches a slow oscillator input. When it sees the first rising edge, it locks into internal mode. In that mode the backplane output is a square wave at one sixteenth of the oscillator frequency. If the oscillator never rises, the block stays in external mode and passes an external backplane input through to the output.

Both slow inputs are asynchronous. Each one passes through a flop synchronizer clocked by a fast sampling clock. The oscillator must run at no more than a quarter of the sampling clock frequency, so that every one of its rising edges is caught. The choice of mode is sticky and only an active-low reset clears it. While reset is held, the backplane output is parked low and does not toggle.

Top module: `bp_src_select`

## Requirements
- R1: While `rst_n` is low, `bp_out` and `int_mode` are both 0, whatever `osc_in` and `ext_bp_in` do. The reset acts asynchronously on assertion.
- R2: Oscillator rising edges that occur while `rst_n` is low do not select internal mode after release. Releasing reset with `osc_in` low leaves `int_mode` at 0.
- R3: The first rising edge of `osc_in` after reset release sets `int_mode` to 1 on the third sampling clock edge after the input change. Before that edge `int_mode` stays 0.
- R4: In internal mode `bp_out` is the top bit of a 4-bit count of oscillator rising edges. The count is 0 on the edge that selects internal mode. `bp_out` is therefore 0 after rising edges 1 to 8, 1 after edges 9 to 16, and 0 again after edges 17 to 24, giving a period of 16 oscillator cycles at 50% duty.
- R5: In external mode `bp_out` equals `ext_bp_in`, delayed by three sampling clock edges.
- R6: Once `int_mode` is 1 it stays 1 until reset. In that state, changes on `ext_bp_in` and a stopped oscillator leave `bp_out` unchanged.
- R7: If `osc_in` is held low, external mode stays selected indefinitely.
- R8: `int_mode` reports the selected source: 1 means internal divider, 0 means external input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| osc_in | input | 1 | Asynchronous oscillator input |
| ext_bp_in | input | 1 | Asynchronous external backplane input |
| bp_out | output | 1 | Backplane output |
| int_mode | output | 1 | 1 = internal divided source selected |

## Verification
The output shows a wrong mode flag immediately. If the flag sets on a stray edge or fails to set, `bp_out` stops following `ext_bp_in` within three clock edges, or keeps following it. A divider count that is off shows up as a misplaced `bp_out` transition; it is visible as soon as the ninth or seventeenth oscillator edge is counted. A flag that is not sticky shows up once the oscillator stops, because `bp_out` then follows a toggling external input again.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic {
        MODE_EXT = 1'b0,
        MODE_INT = 1'b1
    } bp_mode_e;

    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_DIV_BITS    = 4;
endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/bp_rise_det.sv
module bp_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = sig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/bp_core.sv
module bp_core
    import bp_pkg::*;
#(
    parameter int unsigned DIV_BITS = DEF_DIV_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_rise,
    input  logic ext_s,
    output logic bp,
    output logic mode_int
);
    typedef struct packed {
        bp_mode_e            mode;
        logic [DIV_BITS-1:0] cnt;
        logic                bp;
    } core_st_t;

    localparam core_st_t ST_RESET = '{mode: MODE_EXT, cnt: '0, bp: 1'b0};

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (osc_rise) begin
            if (st_q.mode == MODE_EXT) begin
                st_d.mode = MODE_INT;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
        st_d.bp = (st_d.mode == MODE_INT) ? st_d.cnt[DIV_BITS-1] : ext_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign bp       = st_q.bp;
    assign mode_int = (st_q.mode == MODE_INT);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_int |=> mode_int);
    p_select_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_rise && !mode_int) |=> mode_int);
    p_hold_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_rise && !mode_int) |=> !mode_int);
    p_div_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int && !osc_rise) |=> $stable(bp));
    p_ext_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_int && !osc_rise) |=> (bp == $past(ext_s)));
endmodule

// File: rtl/bp_src_select.sv
module bp_src_select
    import bp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned DIV_BITS    = DEF_DIV_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    input  logic ext_bp_in,
    output logic bp_out,
    output logic int_mode
);
    logic osc_s, ext_s, osc_rise;

    bp_sync #(.STAGES(SYNC_STAGES)) u_sync_osc (
        .clk(clk), .rst_n(rst_n), .din(osc_in), .dout(osc_s)
    );

    bp_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .din(ext_bp_in), .dout(ext_s)
    );

    bp_rise_det u_rise (
        .clk(clk), .rst_n(rst_n), .sig(osc_s), .rise(osc_rise)
    );

    bp_core #(.DIV_BITS(DIV_BITS)) u_core (
        .clk(clk), .rst_n(rst_n), .osc_rise(osc_rise), .ext_s(ext_s),
        .bp(bp_out), .mode_int(int_mode)
    );

    p_status_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_mode) |-> $past(osc_rise));
endmodule

// File: tb/tb_bp_src_select.sv
module tb_bp_src_select;
    logic clk = 1'b0;
    logic rst_n, osc_in, ext_bp_in;
    logic bp_out, int_mode;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bp_src_select dut (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .ext_bp_in(ext_bp_in),
        .bp_out(bp_out), .int_mode(int_mode)
    );

    // {ext_bp_in value, expected bp_out}
    localparam logic [1:0] VEC [0:7] = '{
        2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00
    };

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic osc_pulse();
        osc_in = 1'b1;
        repeat (4) @(negedge clk);
        osc_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; osc_in = 1'b0; ext_bp_in = 1'b1;
        repeat (2) @(negedge clk);
        // R1: output parked while in reset, even with toggling inputs
        for (int i = 0; i < 3; i++) osc_pulse();
        check("R1 bp_out in reset", bp_out, 1'b0);
        check("R1 int_mode in reset", int_mode, 1'b0);
        ext_bp_in = 1'b0;
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R2 no mode from reset-time edges", int_mode, 1'b0);

        // R5: table of external-mode vectors
        for (int v = 0; v < 8; v++) begin
            ext_bp_in = VEC[v][1];
            repeat (3) @(posedge clk);
            @(negedge clk);
            check("R5 follow ext", bp_out, VEC[v][0]);
            check("R8 status ext", int_mode, 1'b0);
        end

        // R5 latency: unchanged after two edges, updated on third
        ext_bp_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R5 latency before", bp_out, 1'b0);
        @(negedge clk);
        check("R5 latency after", bp_out, 1'b1);

        // R7: oscillator held low for a long time
        repeat (500) @(negedge clk);
        check("R7 stays external", int_mode, 1'b0);
        check("R7 still follows ext", bp_out, 1'b1);

        // R3: first rising edge selects internal mode on third edge
        osc_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 not yet selected", int_mode, 1'b0);
        @(negedge clk);
        check("R3 selected", int_mode, 1'b1);
        check("R4 count zero at select", bp_out, 1'b0);
        @(negedge clk);
        osc_in = 1'b0;
        repeat (4) @(negedge clk);

        // R4: divider walk over edges 2..33
        for (int k = 2; k <= 33; k++) begin
            osc_pulse();
            check("R4 divided output", bp_out, 1'(((k - 1) >> 3) & 1));
        end

        // R6: sticky mode, external input ignored
        for (int j = 0; j < 20; j++) begin
            ext_bp_in = ~ext_bp_in;
            repeat (5) @(negedge clk);
            check("R6 bp ignores ext", bp_out, 1'b0);
        end
        check("R6 mode sticky", int_mode, 1'b1);
        check("R8 status int", int_mode, 1'b1);

        // R1: reset in internal mode clears at once
        @(negedge clk);
        ext_bp_in = 1'b1;
        rst_n = 1'b0;
        #1;
        check("R1 async bp clear", bp_out, 1'b0);
        check("R1 async mode clear", int_mode, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 external after re-reset", int_mode, 1'b0);
        check("R5 follow ext after re-reset", bp_out, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule